// File: doc/BRIEF.md
# Oversampled SPI Client Receiver

This block is the client end of an SPI link that runs entirely on the local system clock. The serial clock, the data-in line and the active-low select coming from the remote host are not used as clocks. Each one passes through a short synchroniser. The block then finds serial clock edges by comparing consecutive synchronised samples. For this to work, the system clock must run at least twice as fast as the serial clock.

While the client is selected, it does three things:
- It shifts one received bit in on each sample edge.
- It presents one reply bit on MISO on each shift edge.
- It asserts an output enable so that a pad driver can take the shared MISO line.

After a full byte has been received, the byte appears on the receive data output and a sticky completion flag rises. Local logic clears the flag with a one-cycle clear pulse. It can load the next reply byte with a write strobe, for example from an interrupt handler that runs between bytes. If no reply was loaded for a byte, the client shifts out zeros.

Top module: `spi_client_rx`

## Requirements
- R1: The mode input selects the bus timing. Bit 1 gives the serial clock idle level (1 = idle high, so the leading edge is falling). Bit 0 = 0 samples on the leading edge and shifts on the trailing edge. Bit 0 = 1 shifts on the leading edge and samples on the trailing edge. In all four modes the received byte equals the byte the host sent.
- R2: While the select is high, serial clock and data activity has no effect: the flag stays clear and the receive data output keeps its value.
- R3: The MISO output enable is high only while the synchronised select is low. While the enable is low, the MISO output is 0.
- R4: If no reply byte has been loaded since the previous byte was taken, the client shifts out all zero bits.
- R5: After the configured number of bits (8 by default) has been sampled, the receive data output takes the byte and the completion flag goes to 1. A one-cycle pulse on the clear input returns the flag to 0. A completion in the same cycle as a clear wins.
- R6: A reply byte that is written after the flag rises, while the select stays low, is the one shifted out during the next byte of that same selection.
- R7: With the order input at 1, bit 0 is sent and received first. With it at 0, the most significant bit goes first. The order applies to both directions.
- R8: If the select rises in the middle of a byte, the partial byte is discarded: the flag stays clear, the receive data output is unchanged, and the next selection starts counting again from bit zero.
- R9: In modes 0 and 2 the first reply bit is on MISO as soon as the select has fallen, before any serial clock edge. In modes 1 and 3, MISO holds 0 until the first serial clock edge and then carries the first reply bit.
- R10: After reset, the output enable, the MISO output, the flag and the receive data output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_in | input | 1 | Serial clock from the host, asynchronous |
| mosi_in | input | 1 | Serial data from the host, asynchronous |
| ss_n_in | input | 1 | Active-low select from the host, asynchronous |
| cfg_mode | input | 2 | Bus timing mode: bit 1 is the idle clock level, bit 0 selects trailing-edge sampling |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| reply_data | input | DATA_W | Reply byte to be shifted out |
| reply_wr | input | 1 | Write strobe for reply_data |
| flag_clr | input | 1 | Clear pulse for the completion flag |
| rx_data | output | DATA_W | Last complete received byte |
| done_flag | output | 1 | Sticky byte-complete flag |
| miso_out | output | 1 | Serial reply data |
| miso_oe | output | 1 | Output enable for the MISO pad |

## Verification
The bench builds the block with 8-bit bytes and a two-stage synchroniser. It drives the serial clock with a half period of eight system clocks, which is well above the minimum ratio. Margin remains for the three-cycle path from a pin to the edge event, so the bench can sample MISO just before each of its own sample edges in all four modes and in both bit orders. This setup lets the bench test several things directly:
- Holding the select low across two bytes, with a reply written after the first flag.
- Aborting a byte halfway.
- Checking that MISO holds its first bit, or holds zero, before any edge.

// File: rtl/spi_crx_pkg.sv
`timescale 1ns/1ps
package spi_crx_pkg;

  // Events produced by the edge detector for the datapath.
  typedef struct packed {
    logic sel;        // synchronised select active
    logic sel_start;  // first cycle of a selection
    logic sample_ev;  // capture one input bit
    logic shift_ev;   // present the next output bit
  } bus_ev_t;

  // Mode bit 1: clock rests high, leading edge is falling.
  function automatic logic idle_high(input logic [1:0] mode);
    return mode[1];
  endfunction

  // Mode bit 0: sample on trailing edge, shift on leading edge.
  function automatic logic late_sample(input logic [1:0] mode);
    return mode[0];
  endfunction

endpackage

// File: rtl/spi_crx_sync.sv
`timescale 1ns/1ps
module spi_crx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_crx_edge.sv
`timescale 1ns/1ps
module spi_crx_edge
  import spi_crx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       ss_n_s,
  input  logic [1:0] mode,
  output bus_ev_t    ev
);

  logic sck_q;
  logic sel_q;
  logic rise, fall, lead, trail, sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel;
    end
  end

  always_comb begin
    sel   = ~ss_n_s;
    rise  = sck_s & ~sck_q;
    fall  = ~sck_s & sck_q;
    lead  = idle_high(mode) ? fall : rise;
    trail = idle_high(mode) ? rise : fall;
    ev.sel       = sel;
    ev.sel_start = sel & ~sel_q;
    ev.sample_ev = sel & (late_sample(mode) ? trail : lead);
    ev.shift_ev  = sel & (late_sample(mode) ? lead : trail);
  end

endmodule

// File: rtl/spi_crx_rx.sv
`timescale 1ns/1ps
module spi_crx_rx #(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sample_ev,
  input  logic              mosi_s,
  input  logic              lsb_first,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag,
  output logic              byte_done,
  output logic [CNT_W-1:0]  bit_cnt
);

  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] sr_nxt;
  logic              last_bit;

  // Insert a new bit at the end the chosen order fills from.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic b,
                                                 input logic lsb);
    return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
  endfunction

  assign sr_nxt    = shift_in(sr, mosi_s, lsb_first);
  assign last_bit  = (bit_cnt == CNT_W'(DATA_W-1));
  assign byte_done = sample_ev & last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_cnt <= '0;
    end else if (!sel) begin
      sr      <= '0;
      bit_cnt <= '0;
    end else if (sample_ev) begin
      sr      <= sr_nxt;
      bit_cnt <= last_bit ? '0 : bit_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      done_flag <= 1'b0;
    end else begin
      if (byte_done) rx_data <= sr_nxt;
      if (byte_done)     done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_crx_tx.sv
`timescale 1ns/1ps
module spi_crx_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_start,
  input  logic              shift_ev,
  input  logic              at_boundary,
  input  logic              late,
  input  logic              lsb_first,
  input  logic [DATA_W-1:0] reply_data,
  input  logic              reply_wr,
  output logic              miso_q
);

  logic [DATA_W-1:0] reply_q;
  logic              pending;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] src;
  logic              take;

  function automatic logic head(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v,
                                                input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  // A byte starts when the selection opens in early modes, or on a
  // shift edge that falls between bytes.
  assign src  = pending ? reply_q : '0;
  assign take = (sel_start & ~late) | (shift_ev & at_boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_q <= '0;
      pending <= 1'b0;
    end else begin
      if (reply_wr) reply_q <= reply_data;
      if (reply_wr)  pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_q <= 1'b0;
      tx_sr  <= '0;
    end else if (!sel) begin
      miso_q <= 1'b0;
      tx_sr  <= '0;
    end else if (take) begin
      miso_q <= head(src, lsb_first);
      tx_sr  <= advance(src, lsb_first);
    end else if (shift_ev) begin
      miso_q <= head(tx_sr, lsb_first);
      tx_sr  <= advance(tx_sr, lsb_first);
    end
  end

endmodule

// File: rtl/spi_client_rx.sv
`timescale 1ns/1ps
module spi_client_rx
  import spi_crx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_in,
  input  logic              mosi_in,
  input  logic              ss_n_in,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_lsb_first,
  input  logic [DATA_W-1:0] reply_data,
  input  logic              reply_wr,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag,
  output logic              miso_out,
  output logic              miso_oe
);

  // Index 0: serial clock, 1: data in, 2: select (rests high).
  logic [2:0] pins_raw;
  logic [2:0] pins_s;

  assign pins_raw = {ss_n_in, mosi_in, sck_in};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    spi_crx_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(g == 2)
    ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw[g]),
      .q    (pins_s[g])
    );
  end

  // Internal events, named for the checker.
  bus_ev_t          ev;
  logic             sel;
  logic             byte_done;
  logic [CNT_W-1:0] bit_cnt;
  logic             miso_q;

  spi_crx_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sck_s (pins_s[0]),
    .ss_n_s(pins_s[2]),
    .mode  (cfg_mode),
    .ev    (ev)
  );

  assign sel = ev.sel;

  spi_crx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ev.sel),
    .sample_ev(ev.sample_ev),
    .mosi_s   (pins_s[1]),
    .lsb_first(cfg_lsb_first),
    .flag_clr (flag_clr),
    .rx_data  (rx_data),
    .done_flag(done_flag),
    .byte_done(byte_done),
    .bit_cnt  (bit_cnt)
  );

  spi_crx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (ev.sel),
    .sel_start  (ev.sel_start),
    .shift_ev   (ev.shift_ev),
    .at_boundary(bit_cnt == '0),
    .late       (late_sample(cfg_mode)),
    .lsb_first  (cfg_lsb_first),
    .reply_data (reply_data),
    .reply_wr   (reply_wr),
    .miso_q     (miso_q)
  );

  assign miso_oe  = sel;
  assign miso_out = sel & miso_q;

endmodule

// File: rtl/spi_client_rx_chk.sv
`timescale 1ns/1ps
module spi_client_rx_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_n_in,
  input logic              miso_oe,
  input logic              miso_out,
  input logic              done_flag,
  input logic              flag_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              sel,
  input logic              byte_done,
  input logic [CNT_W-1:0]  bit_cnt
);

  // R3: a select pin that was high two edges ago keeps the pad released.
  a_r3_released: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_n_in, 2) |-> (!miso_oe && !miso_out));

  // R2: no byte can complete while deselected.
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !byte_done);

  // R5: completion raises the flag.
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_flag);

  // R5: a clear without a new completion drops the flag.
  a_r5_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && flag_clr && !byte_done) |=> !done_flag);

  // R5: the received byte only changes on completion.
  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_data));

  // R8: leaving the selection restarts the bit count.
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt == '0));

endmodule

bind spi_client_rx spi_client_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ss_n_in  (ss_n_in),
  .miso_oe  (miso_oe),
  .miso_out (miso_out),
  .done_flag(done_flag),
  .flag_clr (flag_clr),
  .rx_data  (rx_data),
  .sel      (sel),
  .byte_done(byte_done),
  .bit_cnt  (bit_cnt)
);

// File: tb/spi_client_rx_test.sv
`timescale 1ns/1ps
module spi_client_rx_test;

  localparam int H = 8;  // serial half period in system clocks

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sck, mosi, ss_n;
  logic [1:0] cfg_mode;
  logic       cfg_lsb;
  logic [7:0] reply_data;
  logic       reply_wr, flag_clr;
  logic [7:0] rx_data;
  logic       done_flag, miso_out, miso_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_client_rx uut (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .mosi_in(mosi), .ss_n_in(ss_n),
    .cfg_mode(cfg_mode), .cfg_lsb_first(cfg_lsb),
    .reply_data(reply_data), .reply_wr(reply_wr), .flag_clr(flag_clr),
    .rx_data(rx_data), .done_flag(done_flag),
    .miso_out(miso_out), .miso_oe(miso_oe)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       lsb;
    logic [7:0] mosi;
    logic [7:0] reply;
    logic       load;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b0, 8'hA5, 8'h3C, 1'b1},
    '{2'd1, 1'b0, 8'h5A, 8'hC3, 1'b1},
    '{2'd2, 1'b0, 8'hF0, 8'h0F, 1'b1},
    '{2'd3, 1'b0, 8'h81, 8'h7E, 1'b1},
    '{2'd0, 1'b1, 8'h01, 8'h80, 1'b1},
    '{2'd3, 1'b1, 8'hC8, 8'h13, 1'b1},
    '{2'd1, 1'b0, 8'h77, 8'h00, 1'b0},
    '{2'd2, 1'b1, 8'hFF, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reply(input logic [7:0] v);
    reply_data = v; reply_wr = 1'b1; cyc(1); reply_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  task automatic select();
    sck = cfg_mode[1]; cyc(4); ss_n = 1'b0; cyc(H);
  endtask

  task automatic deselect();
    cyc(H); ss_n = 1'b1; cyc(H);
  endtask

  // Host side of one byte; returns what was seen on MISO.
  task automatic xbyte(input logic [7:0] tx, output logic [7:0] seen);
    seen = '0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = cfg_lsb ? i : 7 - i;
      if (!cfg_mode[0]) begin
        mosi = tx[idx]; cyc(H); seen[idx] = miso_out;
        sck = ~cfg_mode[1]; cyc(H); sck = cfg_mode[1];
      end else begin
        sck = ~cfg_mode[1]; mosi = tx[idx]; cyc(H); seen[idx] = miso_out;
        sck = cfg_mode[1]; cyc(H);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] seen;
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; ss_n = 1'b1;
    cfg_mode = 2'd0; cfg_lsb = 1'b0; reply_data = '0;
    reply_wr = 1'b0; flag_clr = 1'b0;
    cyc(4);
    check("R10 oe", miso_oe, 0);
    check("R10 flag", done_flag, 0);
    check("R10 rx", rx_data, 0);
    check("R10 miso", miso_out, 0);
    rst_n = 1'b1; cyc(4);
    check("R3 oe idle", miso_oe, 0);

    // Table walk over modes, orders and reply presence (R1, R4, R5, R7).
    for (int v = 0; v < 8; v++) begin
      cfg_mode = VEC[v].mode; cfg_lsb = VEC[v].lsb;
      sck = cfg_mode[1]; cyc(4);
      if (VEC[v].load) write_reply(VEC[v].reply);
      select();
      check("R3 oe selected", miso_oe, 1);
      xbyte(VEC[v].mosi, seen);
      deselect();
      check(VEC[v].lsb ? "R7 rx order" : "R1 rx byte", rx_data, VEC[v].mosi);
      check(VEC[v].load ? "R1 miso byte" : "R4 zero reply", seen,
            VEC[v].load ? VEC[v].reply : 8'h00);
      check("R5 flag set", done_flag, 1);
      check("R3 oe released", miso_oe, 0);
      check("R3 miso released", miso_out, 0);
      clear_flag(); cyc(2);
      check("R5 flag cleared", done_flag, 0);
    end

    // R2: activity while deselected is ignored.
    cfg_mode = 2'd0; cfg_lsb = 1'b0; sck = 1'b0; cyc(4);
    for (int k = 0; k < 16; k++) begin
      mosi = k[0] ^ k[2]; cyc(H/2); sck = ~sck; cyc(H/2);
    end
    cyc(H);
    check("R2 flag", done_flag, 0);
    check("R2 rx hold", rx_data, 8'hFF);
    check("R2 oe", miso_oe, 0);

    // R8: abort halfway, then a full byte counts from zero.
    select();
    for (int k = 0; k < 4; k++) begin
      mosi = 1'b1; cyc(H); sck = 1'b1; cyc(H); sck = 1'b0;
    end
    deselect();
    check("R8 flag after abort", done_flag, 0);
    check("R8 rx after abort", rx_data, 8'hFF);
    select(); xbyte(8'h3D, seen); deselect();
    check("R8 rx after restart", rx_data, 8'h3D);
    clear_flag();

    // R6: reply written after the flag serves the next byte.
    cfg_mode = 2'd3; sck = 1'b1; cyc(4);
    write_reply(8'h11);
    select();
    xbyte(8'hAA, seen);
    check("R6 first miso", seen, 8'h11);
    check("R6 first flag", done_flag, 1);
    write_reply(8'h99);
    clear_flag();
    xbyte(8'h55, seen);
    check("R6 second miso", seen, 8'h99);
    check("R6 second rx", rx_data, 8'h55);
    deselect();
    clear_flag();

    // R9: first bit timing.
    cfg_mode = 2'd2; sck = 1'b1; cyc(4);
    write_reply(8'h80);
    select();
    check("R9 early mode first bit", miso_out, 1);
    deselect();
    cfg_mode = 2'd1; sck = 1'b0; cyc(4);
    write_reply(8'h80);
    select();
    check("R9 late mode before edge", miso_out, 0);
    sck = 1'b1; cyc(H);
    check("R9 late mode after edge", miso_out, 1);
    sck = 1'b0;
    deselect();
    check("R8 flag after late abort", done_flag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule